// File: doc/BRIEF.md
# SONET Serial Frame and Byte Aligner

This block takes a recovered serial line, one bit per clock, and searches it for the SONET framing word. The framing word is three A1 bytes (0xF6) followed by three A2 bytes (0x28). The search can start at any bit offset. Once the word is found, the block fixes the byte boundary and hands out aligned bytes. Each byte comes with a one-cycle byte strobe that fires once every eight bit clocks. A one-cycle frame pulse marks the first correctly aligned byte, which is the third A2.

The search is not free-running. A rising edge on the out-of-frame input arms it. It then stays armed until OOF is low and at least one frame pulse has been issued since that rising edge. So a downstream section terminator can hold OOF high for a frame while it confirms the alignment. It can also drop OOF early, in which case the block keeps searching until the first frame pulse. While the search is disarmed, the byte phase is frozen and framing words at any offset are ignored.

Top module: `sonet_byte_aligner`

## Requirements
- R1: While reset is asserted, and directly after it is released, `fp` is 0 and `pdata` is 0. `byte_en` first pulses on the 8th clock edge after reset is released.
- R2: `byte_en` is high for exactly one clock in every 8. The only exception is a detection, which restarts the 8-clock count from that clock.
- R3: Before any rising edge of `oof_in`, a complete framing word on `sdin` produces no `fp` and does not move the `byte_en` phase.
- R4: When armed, the clock edge that samples the last bit of the third A2 byte sets `fp`, sets `byte_en` and loads `pdata` with 0x28. These three outputs become visible right after that edge.
- R5: After the first detection, each `byte_en` pulse presents the last 8 bits sampled, with the earliest bit in bit 7. Between pulses `pdata` holds its value.
- R6: `fp` is high for a single clock per detection.
- R7: `pdata` stays 0 until the first detection after reset.
- R8: If a detection has occurred since the latest OOF rising edge, the search disarms on the edge where `oof_in` is sampled low. Later framing words at a different offset give no `fp` and leave the phase unchanged.
- R9: While `oof_in` stays high after a detection, the search remains armed. A framing word at a new offset realigns the output and gives a new `fp`.
- R10: If `oof_in` falls before any detection, the search stays armed until the first `fp` and then disarms. A further framing word at another offset is then ignored.
- R11: A new rising edge of `oof_in` re-arms the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdin | input | 1 | Serial recovered data, one bit per clock |
| oof_in | input | 1 | Out-of-frame control; a rising edge arms the search |
| pdata | output | 8 | Aligned parallel byte, earliest bit in bit 7 |
| byte_en | output | 1 | Byte strobe, one clock in eight |
| fp | output | 1 | Frame pulse, coincident with the third A2 byte |

## Verification
The framing word is sent with a random number of leading random bits, so detection is tried at every bit offset of the byte phase. Random payload then follows to confirm that byte slicing and ordering hold after a lock. The same word is also sent before any arming, after a disarm, and while OOF is still held high. These cases separate correct detection from the gating, because a phase jump or a stray pulse shows up only when the word should have been ignored. OOF is dropped both before and after the first frame pulse, which tells the "later of the two events" disarm rule apart from a simple "disarm on OOF low" rule.

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner #(
  parameter int          W   = 8,
  parameter int          N1  = 3,
  parameter int          N2  = 3,
  parameter logic [W-1:0] A1 = 8'hF6,
  parameter logic [W-1:0] A2 = 8'h28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdin,
  input  logic         oof_in,
  output logic [W-1:0] pdata,
  output logic         byte_en,
  output logic         fp
);
  localparam int PW = W * (N1 + N2);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] PAT  = {{N1{A1}}, {N2{A2}}};
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [PW-2:0] sh;
  logic [PW-1:0] nxt;
  logic [CW-1:0] cnt;
  logic          oof_q, armed, found, locked;
  logic          rise, det, be_n, found_n;

  assign nxt     = {sh, sdin};
  assign rise    = oof_in & ~oof_q;
  assign det     = armed && (nxt == PAT);
  assign be_n    = det || (cnt == LAST);
  assign found_n = found | det;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      oof_q <= 1'b0;
    end else begin
      sh <= nxt[PW-2:0];
      oof_q <= oof_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      found <= 1'b0;
    end else if (rise) begin
      armed <= 1'b1;
      found <= 1'b0;
    end else if (armed) begin
      found <= found_n;
      if (!oof_in && found_n) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      byte_en <= 1'b0;
      fp <= 1'b0;
      locked <= 1'b0;
      pdata <= '0;
    end else begin
      cnt <= be_n ? '0 : cnt + 1'b1;
      byte_en <= be_n;
      fp <= det;
      if (det) locked <= 1'b1;
      if (be_n && (locked || det)) pdata <= nxt[W-1:0];
    end
  end

  AST_FP_ON_A2: assert property (@(posedge clk) disable iff (!rst_n)
    fp |-> (byte_en && pdata == A2)); // R4
  AST_FP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp); // R6
  AST_ZERO_UNTIL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> pdata == '0); // R7
  AST_FP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    fp |-> $past(armed)); // R3
  AST_DISARM_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> !$past(oof_in)); // R8
  AST_PDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_en |-> $stable(pdata)); // R5
endmodule

// File: tb/sonet_byte_aligner_tb.sv
module sonet_byte_aligner_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] PATTERN = 48'hF6F6F6_282828;

  logic clk = 1'b0, rst_n = 1'b0, sdin = 1'b0, oof_in = 1'b0;
  logic [7:0] pdata;
  logic byte_en, fp;

  int n_chk = 0, n_bad = 0, cyc = 0, ph = 0;
  logic oof_v = 1'b0, lockedb = 1'b0;
  logic [7:0] hist = 8'h00, epd = 8'h00;

  sonet_byte_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .sdin(sdin), .oof_in(oof_in),
    .pdata(pdata), .byte_en(byte_en), .fp(fp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic send_bit(input logic b, input logic efp, input string tag);
    logic ebe;
    sdin = b;
    oof_in = oof_v;
    @(posedge clk);
    #1;
    hist = {hist[6:0], b};
    if (efp) begin ph = 0; lockedb = 1'b1; end
    else begin ph++; if (ph == 8) ph = 0; end
    ebe = (ph == 0);
    if (ebe && lockedb) epd = hist;
    check(fp === efp, tag, "fp", {7'd0, fp}, {7'd0, efp});
    check(byte_en === ebe, (tag == "R1") ? "R1" : "R2", "byte_en", {7'd0, byte_en}, {7'd0, ebe});
    check(pdata === epd, lockedb ? "R5" : "R7", "pdata", pdata, epd);
  endtask

  task automatic send_rand(input int n, input string tag);
    for (int i = 0; i < n; i++) send_bit(1'($urandom), 1'b0, tag);
  endtask

  task automatic send_pat(input logic hit, input string tag);
    for (int i = 47; i >= 0; i--) send_bit(PATTERN[i], hit && (i == 0), tag);
  endtask

  initial begin
    int k;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    check(fp === 1'b0, "R1", "fp in reset", {7'd0, fp}, 8'd0);
    check(byte_en === 1'b0, "R1", "byte_en in reset", {7'd0, byte_en}, 8'd0);
    check(pdata === 8'h00, "R1", "pdata in reset", pdata, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) send_bit(1'b0, 1'b0, "R1");
    // R3: pattern before any arming is ignored
    send_rand(5, "R3");
    send_pat(1'b0, "R3");
    send_rand(11, "R3");
    // R4/R11: arm and detect at a random offset
    oof_v = 1'b1;
    send_rand(3, "R11");
    send_rand(int'($urandom_range(0, 7)), "R4");
    send_pat(1'b1, "R4");
    send_rand(32, "R5");
    // R9: still armed with OOF high; realign at a new offset
    send_rand(3, "R9");
    send_pat(1'b1, "R9");
    send_rand(16, "R9");
    // R8: OOF falls after a detection; disarmed
    oof_v = 1'b0;
    send_rand(4, "R8");
    send_rand(5, "R8");
    send_pat(1'b0, "R8");
    send_rand(13, "R8");
    // R10: OOF pulse shorter than the search; still armed until first fp
    oof_v = 1'b1;
    send_rand(2, "R10");
    oof_v = 1'b0;
    send_rand(6, "R10");
    send_pat(1'b1, "R10");
    send_rand(2, "R10");
    send_pat(1'b0, "R10");
    send_rand(10, "R10");
    // R6 and random mix: re-arm, random offsets, random payload
    for (int it = 0; it < 12; it++) begin
      oof_v = 1'b1;
      send_rand(2, "R11");
      k = int'($urandom_range(0, 15));
      send_rand(k, "R11");
      send_pat(1'b1, "R11");
      send_rand(int'($urandom_range(8, 40)), "R6");
      oof_v = 1'b0;
      send_rand(3, "R8");
      send_rand(int'($urandom_range(0, 7)), "R8");
      send_pat(1'b0, "R8");
      send_rand(9, "R8");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule